// File: doc/BRIEF.md
# Collapsing Issue Queue with Arbiter-Tree Select

This block is a central instruction window for an out-of-order core. The dispatch stage writes one instruction per cycle into it. Each instruction carries two source tags, a ready flag for each tag, and an opaque payload. A result bus broadcasts the tag of each value as it is produced. Every stored entry compares that tag with both of its sources and marks a source ready when it matches. An entry whose two sources are both ready requests issue.

A tree of four-input arbiter cells picks one requester per cycle. Request summaries travel up from the leaf cells to the root. The root grants only while the functional unit says it can accept an instruction, and the grant travels back down to exactly one entry. Priority comes from position: position 0 is the oldest instruction and wins. The queue keeps its age order by collapsing. When an entry leaves, every entry above it moves down one slot, and a new instruction goes into the lowest empty slot.

Wakeup and select happen in the same cycle, so an instruction can issue on the same clock edge that samples its last broadcast. The issued payload and the full flag come from registers.

Top module: `iqts_issue_queue`

## Requirements
- R1: After a synchronous reset the queue is empty, and `iss_valid` and `q_full` are 0.
- R2: An instruction dispatched with both ready flags set is presented on `iss_valid`/`iss_payload` right after the edge that follows its dispatch edge, provided `fu_ready` is high in that cycle.
- R3: A broadcast (`wb_valid`=1) whose tag equals a waiting source tag marks that source ready. If this makes the entry fully ready, it issues on the same edge that samples the broadcast.
- R4: A broadcast whose tag matches no waiting source, or a tag presented with `wb_valid`=0, wakes nothing.
- R5: At most one instruction issues per edge, and none issues on an edge where `fu_ready` is 0.
- R6: When several entries are ready, the one in the lowest position issues. A lower position always means an older instruction.
- R7: After an issue, the entries above the issued one move down one position, keeping their relative order. New instructions are written at the lowest free position, so issue order follows dispatch order among ready entries.
- R8: `q_full` is 1 exactly when all DEPTH (16) entries are valid. While it is 1, a dispatch is discarded, even if an entry issues on the same edge.
- R9: A source of a dispatched instruction whose tag equals a broadcast on the dispatch edge is stored as ready.
- R10: An issued entry is removed and never issues again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dsp_valid | input | 1 | Dispatch write request |
| dsp_tag_a | input | TAG_W | First source tag |
| dsp_rdy_a | input | 1 | First source already available |
| dsp_tag_b | input | TAG_W | Second source tag |
| dsp_rdy_b | input | 1 | Second source already available |
| dsp_payload | input | PAY_W | Instruction payload |
| wb_valid | input | 1 | Result tag broadcast valid |
| wb_tag | input | TAG_W | Broadcast result tag |
| fu_ready | input | 1 | Functional unit can accept an instruction |
| iss_valid | output | 1 | An instruction issued on the last edge |
| iss_payload | output | PAY_W | Payload of the issued instruction |
| q_full | output | 1 | All entries valid |

## Verification
The assertions check, on every cycle, the properties that hold no matter what the stimulus is. The grant vector is one-hot or zero and covers only requesting entries. Nothing issues while the unit is not ready. The valid entries form a packed run starting at position 0. An issue without an accepted dispatch lowers the occupancy by exactly one. A full queue with the unit stalled stays full.

Other behaviours only show in the bench's scenarios, because they depend on values and ordering: which payload issues, the oldest-first choice among several ready entries, the order that survives collapsing, wakeup by the broadcast tag (including one that arrives on the dispatch edge), tags that must not wake anything, and the silent loss of a dispatch into a full queue.

// File: rtl/iqts_pkg.sv
package iqts_pkg;
  parameter int TAG_W = 6;
  parameter int PAY_W = 16;

  typedef struct packed {
    logic [TAG_W-1:0] tag_a;
    logic             rdy_a;
    logic [TAG_W-1:0] tag_b;
    logic             rdy_b;
    logic [PAY_W-1:0] pay;
  } iq_entry_t;
endpackage

// File: rtl/iqts_arb_cell.sv
module iqts_arb_cell #(
  parameter int FAN = 4
) (
  input  logic [FAN-1:0] req,
  input  logic           en,
  output logic           any,
  output logic [FAN-1:0] gnt
);
  logic taken;

  always_comb begin
    any   = |req;
    gnt   = '0;
    taken = 1'b0;
    for (int i = 0; i < FAN; i++) begin
      if (en && req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iqts_select_tree.sv
module iqts_select_tree #(
  parameter int FAN = 4,
  localparam int N = FAN * FAN
) (
  input  logic [N-1:0] req,
  input  logic         en,
  output logic         any,
  output logic [N-1:0] gnt
);
  logic [FAN-1:0] grp_any;
  logic [FAN-1:0] grp_en;

  for (genvar g = 0; g < FAN; g++) begin : g_leaf
    iqts_arb_cell #(.FAN(FAN)) u_leaf (
      .req (req[g*FAN +: FAN]),
      .en  (grp_en[g]),
      .any (grp_any[g]),
      .gnt (gnt[g*FAN +: FAN])
    );
  end

  iqts_arb_cell #(.FAN(FAN)) u_root (
    .req (grp_any),
    .en  (en),
    .any (any),
    .gnt (grp_en)
  );
endmodule

// File: rtl/iqts_issue_queue.sv
module iqts_issue_queue
  import iqts_pkg::*;
#(
  parameter int FAN = 4,
  localparam int DEPTH = FAN * FAN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dsp_valid,
  input  logic [TAG_W-1:0] dsp_tag_a,
  input  logic             dsp_rdy_a,
  input  logic [TAG_W-1:0] dsp_tag_b,
  input  logic             dsp_rdy_b,
  input  logic [PAY_W-1:0] dsp_payload,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic             fu_ready,
  output logic             iss_valid,
  output logic [PAY_W-1:0] iss_payload,
  output logic             q_full
);
  iq_entry_t        ent_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  iq_entry_t        woke  [DEPTH+1];
  iq_entry_t        nxt_ent [DEPTH];
  logic [DEPTH:0]   vld_ext;
  logic [DEPTH-1:0] nxt_vld;
  logic [DEPTH-1:0] req;
  logic [DEPTH-1:0] gnt;
  logic [DEPTH-1:0] past_gnt;
  logic [DEPTH-1:0] sh_vld;
  logic [DEPTH-1:0] below_vld;
  logic             tree_any;
  logic             accept;
  iq_entry_t        new_ent;
  logic [PAY_W-1:0] sel_pay;

  // wakeup: compare broadcast against every stored source
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      woke[i] = ent_q[i];
      if (wb_valid && wb_tag == ent_q[i].tag_a) woke[i].rdy_a = 1'b1;
      if (wb_valid && wb_tag == ent_q[i].tag_b) woke[i].rdy_b = 1'b1;
      req[i] = vld_q[i] && woke[i].rdy_a && woke[i].rdy_b;
    end
    woke[DEPTH] = '0;
    vld_ext     = {1'b0, vld_q};
  end

  iqts_select_tree #(.FAN(FAN)) u_tree (
    .req (req),
    .en  (fu_ready),
    .any (tree_any),
    .gnt (gnt)
  );

  // collapse: entries at or above the granted slot take their upper neighbour
  always_comb begin
    logic acc;
    acc     = 1'b0;
    sel_pay = '0;
    for (int i = 0; i < DEPTH; i++) begin
      acc         = acc | gnt[i];
      past_gnt[i] = acc;
      sel_pay     = sel_pay | ({PAY_W{gnt[i]}} & ent_q[i].pay);
    end
  end

  always_comb begin
    accept        = dsp_valid && !vld_q[DEPTH-1];
    new_ent.tag_a = dsp_tag_a;
    new_ent.tag_b = dsp_tag_b;
    new_ent.pay   = dsp_payload;
    new_ent.rdy_a = dsp_rdy_a || (wb_valid && wb_tag == dsp_tag_a);
    new_ent.rdy_b = dsp_rdy_b || (wb_valid && wb_tag == dsp_tag_b);
    for (int i = 0; i < DEPTH; i++) begin
      if (past_gnt[i]) begin
        nxt_ent[i] = woke[i+1];
        sh_vld[i]  = vld_ext[i+1];
      end else begin
        nxt_ent[i] = woke[i];
        sh_vld[i]  = vld_ext[i];
      end
    end
    below_vld = {sh_vld[DEPTH-2:0], 1'b1};
    for (int i = 0; i < DEPTH; i++) begin
      nxt_vld[i] = sh_vld[i];
      if (accept && !sh_vld[i] && below_vld[i]) begin
        nxt_ent[i] = new_ent;
        nxt_vld[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q       <= '0;
      iss_valid   <= 1'b0;
      iss_payload <= '0;
    end else begin
      vld_q       <= nxt_vld;
      iss_valid   <= |gnt;
      iss_payload <= sel_pay;
    end
  end

  // entry storage carries no reset; validity lives in vld_q
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) ent_q[i] <= nxt_ent[i];
  end

  assign q_full = vld_q[DEPTH-1];

  // ---------------- assertions ----------------
  assert_one_grant_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && ((gnt & ~req) == '0));

  assert_unit_gate_R5: assert property (@(posedge clk) disable iff (rst)
    !fu_ready |=> !iss_valid);

  assert_packed_R7: assert property (@(posedge clk) disable iff (rst)
    (((vld_q >> 1) & ~vld_q) == '0));

  assert_full_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (q_full && !fu_ready) |=> q_full);

  assert_issue_removes_R10: assert property (@(posedge clk) disable iff (rst)
    ((|gnt) && !accept) |=> ($countones(vld_q) == $countones($past(vld_q)) - 1));

  assert_any_matches_R6: assert property (@(posedge clk) disable iff (rst)
    (tree_any && fu_ready) |-> (|gnt));
endmodule

// File: tb/iqts_issue_queue_bench.sv
module iqts_issue_queue_bench;
  import iqts_pkg::*;

  logic             clk = 1'b0;
  logic             rst;
  logic             dsp_valid;
  logic [TAG_W-1:0] dsp_tag_a;
  logic             dsp_rdy_a;
  logic [TAG_W-1:0] dsp_tag_b;
  logic             dsp_rdy_b;
  logic [PAY_W-1:0] dsp_payload;
  logic             wb_valid;
  logic [TAG_W-1:0] wb_tag;
  logic             fu_ready;
  logic             iss_valid;
  logic [PAY_W-1:0] iss_payload;
  logic             q_full;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  iqts_issue_queue u_iqts_issue_queue (
    .clk(clk), .rst(rst),
    .dsp_valid(dsp_valid), .dsp_tag_a(dsp_tag_a), .dsp_rdy_a(dsp_rdy_a),
    .dsp_tag_b(dsp_tag_b), .dsp_rdy_b(dsp_rdy_b), .dsp_payload(dsp_payload),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .fu_ready(fu_ready),
    .iss_valid(iss_valid), .iss_payload(iss_payload), .q_full(q_full)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_issue(string req, logic v, logic [PAY_W-1:0] p);
    chk(req, {31'd0, iss_valid}, {31'd0, v});
    if (v) chk(req, {16'd0, iss_payload}, {16'd0, p});
  endtask

  task automatic disp(logic [TAG_W-1:0] ta, logic ra, logic [TAG_W-1:0] tb, logic rb,
                      logic [PAY_W-1:0] p);
    dsp_valid = 1'b1; dsp_tag_a = ta; dsp_rdy_a = ra;
    dsp_tag_b = tb; dsp_rdy_b = rb; dsp_payload = p;
  endtask

  task automatic idle();
    dsp_valid = 1'b0; wb_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(); fu_ready = 1'b0; wb_tag = '0;
    dsp_tag_a = '0; dsp_tag_b = '0; dsp_rdy_a = 0; dsp_rdy_b = 0; dsp_payload = '0;
    tick(); tick();
    rst = 1'b0;
    tick();
    chk("R1 valid", {31'd0, iss_valid}, 0);
    chk("R1 full", {31'd0, q_full}, 0);
  endtask

  task automatic t_basic();
    disp(6'd1, 1, 6'd2, 1, 16'h00A1);
    tick();
    idle(); fu_ready = 1'b1;
    tick();
    expect_issue("R2", 1, 16'h00A1);
    tick();
    expect_issue("R10", 0, '0);
  endtask

  task automatic t_wakeup();
    disp(6'd5, 0, 6'd3, 1, 16'h00B2);
    tick();
    idle(); wb_valid = 1'b1; wb_tag = 6'd6;
    tick();
    expect_issue("R4 other tag", 0, '0);
    wb_valid = 1'b0; wb_tag = 6'd5;
    tick();
    expect_issue("R4 tag without valid", 0, '0);
    wb_valid = 1'b1;
    tick();
    expect_issue("R3", 1, 16'h00B2);
    wb_valid = 1'b0;
    tick();
    expect_issue("R10 after wake", 0, '0);
  endtask

  task automatic t_gate();
    fu_ready = 1'b0;
    disp(6'd1, 1, 6'd1, 1, 16'h00C3);
    tick();
    idle();
    tick();
    expect_issue("R5 stalled", 0, '0);
    tick();
    expect_issue("R5 stalled again", 0, '0);
    fu_ready = 1'b1;
    tick();
    expect_issue("R5 released", 1, 16'h00C3);
  endtask

  task automatic t_priority();
    fu_ready = 1'b0;
    disp(6'd7, 0, 6'd1, 1, 16'h00D4); tick();
    disp(6'd1, 1, 6'd1, 1, 16'h00E5); tick();
    disp(6'd2, 1, 6'd2, 1, 16'h00F6); tick();
    idle(); fu_ready = 1'b1;
    tick();
    expect_issue("R6 oldest ready", 1, 16'h00E5);
    wb_valid = 1'b1; wb_tag = 6'd7;
    tick();
    expect_issue("R6 lower position wins", 1, 16'h00D4);
    wb_valid = 1'b0;
    tick();
    expect_issue("R7 shifted entry", 1, 16'h00F6);
    tick();
    expect_issue("R10 drained", 0, '0);
  endtask

  task automatic t_full();
    fu_ready = 1'b0;
    for (int i = 0; i < 16; i++) begin
      disp(6'd1, 1, 6'd1, 1, 16'h0100 + 16'(i));
      tick();
      if (i == 14) chk("R8 not yet full", {31'd0, q_full}, 0);
    end
    idle();
    chk("R8 full", {31'd0, q_full}, 1);
    disp(6'd1, 1, 6'd1, 1, 16'h01FF);
    fu_ready = 1'b1;
    tick();
    idle();
    expect_issue("R8 issue while full", 1, 16'h0100);
    chk("R8 full drops", {31'd0, q_full}, 0);
    for (int i = 1; i < 16; i++) begin
      tick();
      expect_issue("R7 dispatch order", 1, 16'h0100 + 16'(i));
    end
    tick();
    expect_issue("R8 rejected write absent", 0, '0);
  endtask

  task automatic t_disp_wake();
    fu_ready = 1'b1;
    disp(6'd9, 0, 6'd4, 1, 16'h0777);
    wb_valid = 1'b1; wb_tag = 6'd9;
    tick();
    idle();
    expect_issue("R9 not same edge", 0, '0);
    tick();
    expect_issue("R9", 1, 16'h0777);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_wakeup();
        t_gate();
        t_priority();
        t_full();
        t_disp_wake();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule